// File: doc/BRIEF.md
# System Bus Error Status Register

This block keeps the error status that a CPU module collects about the system bus it sits on. It watches per-longword parity-error strobes together with the phase of the bus transaction in which they arrive. Parity errors raised during the command/address cycle are logged in one class. Errors raised during either of the two data cycles are logged in a second class. Each class has one summary bit and a set of per-longword detail bits. The detail bits keep the pattern of the first error of the class until software clears that class's summary bit.

The block also watches for a bus retry that arrives while retries are not enabled. When that happens it sets a sticky retry-failure bit. It also returns a hard-error acknowledge code for the CPU command that was retried. That code is the only report of the event. The block drives no bus error line and no interrupt.

Software reads the whole state as one 16-bit status word. It clears bits by writing ones through a single write port. Parity generation and the bus protocol engine sit outside this block.

Top module: `sbe_status_reg`

## Requirements
- R1: After reset the status word reads 0 and the acknowledge code is 2'b00.
- R2: With `bus_phase`=2'b10 (first data cycle), an error on longword 1 sets status bit 10 and an error on longword 3 sets bit 11. With `bus_phase`=2'b11 (second data cycle), an error on longword 5 sets bit 12 and an error on longword 7 sets bit 13. Any such error also sets the data summary bit 1. Each change is visible one cycle after the strobe.
- R3: With `bus_phase`=2'b01 (command/address cycle), an error on longword 1 sets status bit 8 and an error on longword 3 sets bit 9. Either one also sets the command/address summary bit 0.
- R4: While a summary bit is set and is not being cleared, new errors of its class leave that class's detail bits unchanged.
- R5: Writing 1 to summary bit 0 or bit 1 clears that summary bit and its detail bits. An error of the same class that arrives in the same cycle as the clear is logged as a fresh pattern.
- R6: A strobe on `retry_seen` while `retry_en` is 0 sets status bit 2 one cycle later. Writing 1 to bit 2 clears it. If a set and a clear arrive in the same cycle, the set wins.
- R7: One cycle after `retry_seen`, `ack_code` reads 2'b11 (hard error) if `retry_en` was 0 and 2'b01 (retry) if it was 1. In every other cycle it reads 2'b00.
- R8: Status bits 3 and 4 are clear-on-write-one bits that hardware never sets, so they always read 0.
- R9: Parity strobes with `bus_phase`=2'b00 (idle) have no effect. Strobes on longwords other than those named in R2 and R3 for the current phase also have no effect.
- R10: Writing 0 to any bit, and writing to any bit other than 0 to 4, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| lw_par_err | input | LW_COUNT | Per-longword parity-error strobes |
| bus_phase | input | 2 | Transaction phase: 00 idle, 01 command/address, 10 first data, 11 second data |
| retry_seen | input | 1 | A bus retry was observed this cycle |
| retry_en | input | 1 | Retry enable from the control register |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 16 | Write data; a 1 clears the matching clearable bit |
| status | output | 16 | Readable status word |
| ack_code | output | 2 | Acknowledge code for the retried command |

## Verification
The bench builds the block with its default of eight longword strobes. This exposes every longword that has no meaning in each phase, so R9 can be checked with real stimulus. It runs directed sequences first: errors while a summary bit is held, clears that coincide with new errors, and a retry set that coincides with a clear. After that it runs a long stretch of random strobes, phases and writes. A behavioural model in the bench predicts the status word and the acknowledge code in every cycle, and the bench compares both each cycle.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_CA   = 2'b01,
    PH_D0   = 2'b10,
    PH_D1   = 2'b11
  } phase_t;

  typedef enum logic [1:0] {
    ACK_NONE  = 2'b00,
    ACK_RETRY = 2'b01,
    ACK_HARD  = 2'b11
  } ack_t;

  localparam int BIT_CA_SUM   = 0;
  localparam int BIT_DATA_SUM = 1;
  localparam int BIT_RETRY    = 2;
  localparam int BIT_SPARE0   = 3;
  localparam int CA_DET_LO    = 8;
  localparam int CA_DET_W     = 2;
  localparam int DATA_DET_LO  = 10;
  localparam int DATA_DET_W   = 4;
  localparam int W1C_COUNT    = 3;

  // command/address class: longwords 1 and 3 during the C/A cycle
  function automatic logic [CA_DET_W-1:0] ca_errs(input logic [7:0] lw, input logic [1:0] ph);
    ca_errs = (ph == PH_CA) ? {lw[3], lw[1]} : '0;
  endfunction

  // data class: 1/3 in the first data cycle, 5/7 in the second
  function automatic logic [DATA_DET_W-1:0] data_errs(input logic [7:0] lw, input logic [1:0] ph);
    case (ph)
      PH_D0:   data_errs = {2'b00, lw[3], lw[1]};
      PH_D1:   data_errs = {lw[7], lw[5], 2'b00};
      default: data_errs = '0;
    endcase
  endfunction

  function automatic ack_t ack_for(input logic seen, input logic en);
    if (!seen)   ack_for = ACK_NONE;
    else if (en) ack_for = ACK_RETRY;
    else         ack_for = ACK_HARD;
  endfunction
endpackage

// File: rtl/sbe_sticky_group.sv
module sbe_sticky_group #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] new_err,
  input  logic         clr,
  output logic         sum,
  output logic [W-1:0] detail
);
  logic held;
  logic any_new;

  assign held    = sum && !clr;
  assign any_new = |new_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum    <= 1'b0;
      detail <= '0;
    end else if (held) begin
      sum    <= 1'b1;
      detail <= detail;
    end else begin
      sum    <= any_new;
      detail <= new_err;
    end
  end
endmodule

// File: rtl/sbe_w1c_bit.sv
module sbe_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/sbe_retry_chk.sv
module sbe_retry_chk
  import sbe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       retry_seen,
  input  logic       retry_en,
  output logic       fail_set,
  output logic [1:0] ack_code
);
  ack_t ack_q;

  assign fail_set = retry_seen && !retry_en;
  assign ack_code = ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= ACK_NONE;
    else        ack_q <= ack_for(retry_seen, retry_en);
  end
endmodule

// File: rtl/sbe_status_reg.sv
module sbe_status_reg
  import sbe_pkg::*;
#(
  parameter int LW_COUNT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LW_COUNT-1:0] lw_par_err,
  input  logic [1:0]          bus_phase,
  input  logic                retry_seen,
  input  logic                retry_en,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    status,
  output logic [1:0]          ack_code
);
  localparam int LW_USED = 8;

  logic [LW_USED-1:0]    lw8;
  logic [CA_DET_W-1:0]   ca_new;
  logic [DATA_DET_W-1:0] data_new;
  logic                  ca_clr, data_clr;
  logic                  ca_sum, data_sum;
  logic [CA_DET_W-1:0]   ca_det;
  logic [DATA_DET_W-1:0] data_det;
  logic                  retry_fail_set;
  logic [W1C_COUNT-1:0]  w1c_set, w1c_clr, w1c_q;

  generate
    if (LW_COUNT >= LW_USED) begin : g_wide
      assign lw8 = lw_par_err[LW_USED-1:0];
    end else begin : g_narrow
      assign lw8 = {{(LW_USED-LW_COUNT){1'b0}}, lw_par_err};
    end
  endgenerate

  assign ca_new   = ca_errs(lw8, bus_phase);
  assign data_new = data_errs(lw8, bus_phase);
  assign ca_clr   = wr_en && wr_data[BIT_CA_SUM];
  assign data_clr = wr_en && wr_data[BIT_DATA_SUM];

  sbe_sticky_group #(.W(CA_DET_W)) u_ca (
    .clk(clk), .rst_n(rst_n), .new_err(ca_new), .clr(ca_clr),
    .sum(ca_sum), .detail(ca_det)
  );

  sbe_sticky_group #(.W(DATA_DET_W)) u_data (
    .clk(clk), .rst_n(rst_n), .new_err(data_new), .clr(data_clr),
    .sum(data_sum), .detail(data_det)
  );

  sbe_retry_chk u_retry (
    .clk(clk), .rst_n(rst_n), .retry_seen(retry_seen), .retry_en(retry_en),
    .fail_set(retry_fail_set), .ack_code(ack_code)
  );

  // bit 0 of this bank: retry failure; bits 1..2: spare bits, never set
  assign w1c_set = {{(W1C_COUNT-1){1'b0}}, retry_fail_set};

  genvar gi;
  generate
    for (gi = 0; gi < W1C_COUNT; gi++) begin : g_w1c
      assign w1c_clr[gi] = wr_en && wr_data[BIT_RETRY+gi];
      sbe_w1c_bit u_bit (
        .clk(clk), .rst_n(rst_n), .set(w1c_set[gi]), .clr(w1c_clr[gi]), .q(w1c_q[gi])
      );
    end
  endgenerate

  always_comb begin
    status = '0;
    status[BIT_CA_SUM]   = ca_sum;
    status[BIT_DATA_SUM] = data_sum;
    status[BIT_RETRY +: W1C_COUNT]       = w1c_q;
    status[CA_DET_LO +: CA_DET_W]        = ca_det;
    status[DATA_DET_LO +: DATA_DET_W]    = data_det;
  end
endmodule

// File: rtl/sbe_status_chk.sv
module sbe_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_phase,
  input logic        retry_seen,
  input logic        retry_en,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] status,
  input logic [1:0]  ack_code,
  input logic        ca_new_any,
  input logic        data_new_any
);
  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] && !(wr_en && wr_data[1]) |=> $stable(status[13:10]) && status[1]);

  a_r4_ca_hold: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] && !(wr_en && wr_data[0]) |=> $stable(status[9:8]) && status[0]);

  a_r2_sum_matches_detail: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] == (|status[13:10])) && (status[0] == (|status[9:8])));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ca_new_any && !data_new_any && !(wr_en && (wr_data[1] || wr_data[0]))
      |=> $stable(status[13:8]) && $stable(status[1:0]));

  a_r6_retry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    retry_seen && !retry_en |=> status[2]);

  a_r7_hard_ack: assert property (@(posedge clk) disable iff (!rst_n)
    retry_seen && !retry_en |=> ack_code == 2'b11);

  a_r7_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !retry_seen |=> ack_code == 2'b00);

  a_r8_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[4:3] == 2'b00 && status[7:5] == 3'b000 && status[15:14] == 2'b00);
endmodule

bind sbe_status_reg sbe_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .retry_seen(retry_seen),
  .retry_en(retry_en), .wr_en(wr_en), .wr_data(wr_data), .status(status),
  .ack_code(ack_code), .ca_new_any(|ca_new), .data_new_any(|data_new)
);

// File: tb/sbe_status_reg_test.sv
module sbe_status_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int LWN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LWN-1:0] lw_par_err = '0;
  logic [1:0] bus_phase = 2'b00;
  logic retry_seen = 1'b0, retry_en = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] status;
  logic [1:0] ack_code;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit m_ca_sum, m_d_sum, m_retry;
  bit m_ca[4], m_d[8];   // indexed by longword number
  int m_ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbe_status_reg #(.LW_COUNT(LWN)) uut (
    .clk(clk), .rst_n(rst_n), .lw_par_err(lw_par_err), .bus_phase(bus_phase),
    .retry_seen(retry_seen), .retry_en(retry_en), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .ack_code(ack_code)
  );

  function automatic int model_word();
    int w = 0;
    if (m_ca_sum) w += 1;
    if (m_d_sum)  w += 2;
    if (m_retry)  w += 4;
    if (m_ca[1])  w += 256;
    if (m_ca[3])  w += 512;
    if (m_d[1])   w += 1024;
    if (m_d[3])   w += 2048;
    if (m_d[5])   w += 4096;
    if (m_d[7])   w += 8192;
    return w;
  endfunction

  task automatic model_reset();
    m_ca_sum = 0; m_d_sum = 0; m_retry = 0; m_ack = 0;
    foreach (m_ca[i]) m_ca[i] = 0;
    foreach (m_d[i]) m_d[i] = 0;
  endtask

  // advance the model by one clock using the inputs currently driven
  task automatic model_step();
    bit clr_ca = wr_en && wr_data[0];
    bit clr_d  = wr_en && wr_data[1];
    bit nca[4], nd[8];
    bit any_ca = 0, any_d = 0;
    foreach (nca[i]) nca[i] = 0;
    foreach (nd[i]) nd[i] = 0;
    if (bus_phase == 2'b01) begin
      nca[1] = lw_par_err[1]; nca[3] = lw_par_err[3];
    end else if (bus_phase == 2'b10) begin
      nd[1] = lw_par_err[1]; nd[3] = lw_par_err[3];
    end else if (bus_phase == 2'b11) begin
      nd[5] = lw_par_err[5]; nd[7] = lw_par_err[7];
    end
    foreach (nca[i]) any_ca |= nca[i];
    foreach (nd[i]) any_d |= nd[i];
    if (!(m_ca_sum && !clr_ca)) begin
      m_ca = nca; m_ca_sum = any_ca;
    end
    if (!(m_d_sum && !clr_d)) begin
      m_d = nd; m_d_sum = any_d;
    end
    if (retry_seen && !retry_en) m_retry = 1;
    else if (wr_en && wr_data[2]) m_retry = 0;
    m_ack = !retry_seen ? 0 : (retry_en ? 1 : 3);
  endtask

  task automatic check(input string tag);
    int exp = model_word();
    checks++;
    if (status !== exp[15:0]) begin
      fails++;
      $display("FAIL %s status actual=%h expected=%h", tag, status, exp[15:0]);
    end
    checks++;
    if (ack_code !== m_ack[1:0]) begin
      fails++;
      $display("FAIL %s ack_code actual=%b expected=%b", tag, ack_code, m_ack[1:0]);
    end
  endtask

  // inputs already set at a negedge; clock, step model, compare at next negedge
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  task automatic drive(input logic [7:0] lw, input logic [1:0] ph, input logic rs,
                       input logic re, input logic we, input logic [15:0] wd);
    lw_par_err = lw; bus_phase = ph; retry_seen = rs; retry_en = re;
    wr_en = we; wr_data = wd;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    drive(8'h00, 2'b00, 0, 0, 0, 16'h0); cyc("R1");

    // R9: idle phase and unused longwords
    drive(8'hFF, 2'b00, 0, 0, 0, 16'h0); cyc("R9");
    drive(8'hF5, 2'b01, 0, 0, 0, 16'h0); cyc("R9");
    drive(8'h00, 2'b00, 0, 0, 1, 16'h0003); cyc("R5");
    drive(8'h55, 2'b10, 0, 0, 0, 16'h0); cyc("R9");
    drive(8'h00, 2'b00, 0, 0, 1, 16'h0003); cyc("R5");

    // R2 data cycles
    drive(8'h02, 2'b10, 0, 0, 0, 16'h0); cyc("R2");
    drive(8'hA0, 2'b11, 0, 0, 0, 16'h0); cyc("R4");
    drive(8'h00, 2'b00, 0, 0, 1, 16'h0002); cyc("R5");
    drive(8'h80, 2'b11, 0, 0, 0, 16'h0); cyc("R2");
    // R5: clear coincides with a new error
    drive(8'h08, 2'b10, 0, 0, 1, 16'h0002); cyc("R5");

    // R3 command/address
    drive(8'h08, 2'b01, 0, 0, 0, 16'h0); cyc("R3");
    drive(8'h0A, 2'b01, 0, 0, 0, 16'h0); cyc("R4");
    drive(8'h00, 2'b00, 0, 0, 1, 16'hFFE0); cyc("R10");
    drive(8'h00, 2'b00, 0, 0, 0, 16'hFFFF); cyc("R10");
    drive(8'h00, 2'b00, 0, 0, 1, 16'h0001); cyc("R5");

    // R6/R7 retry
    drive(8'h00, 2'b00, 1, 1, 0, 16'h0); cyc("R7");
    drive(8'h00, 2'b00, 1, 0, 0, 16'h0); cyc("R6");
    drive(8'h00, 2'b00, 0, 0, 0, 16'h0); cyc("R7");
    drive(8'h00, 2'b00, 1, 0, 1, 16'h0004); cyc("R6");
    drive(8'h00, 2'b00, 0, 0, 1, 16'h0004); cyc("R6");
    drive(8'h00, 2'b00, 0, 0, 1, 16'h0018); cyc("R8");

    // random stretch
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] lw = $urandom();
      logic [1:0] ph = $urandom();
      logic we = ($urandom_range(0, 7) == 0);
      drive(lw & {8{($urandom_range(0, 3) == 0)}}, ph, ($urandom_range(0, 5) == 0),
            $urandom(), we, $urandom());
      cyc("R4");
    end

    // reset mid-run
    drive(8'h00, 2'b00, 0, 0, 0, 16'h0);
    rst_n = 1'b0; model_reset();
    @(negedge clk); check("R1");
    rst_n = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule